// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out a multi-register load or store as a series of single-word memory accesses. A request carries a register-selection mask, a base address, an addressing mode, a direction flag and a base-update flag. After accepting the request, the block walks the selected registers from the lowest index to the highest. It presents one access per register on a memory port that uses a valid/ready handshake. Each access carries a word address that rises by one word at a time.

Loads place the returned words into a built-in register file model. Stores take their data from that register file. The register file also has a side port, so that its contents can be preset and observed. At the end of the operation the block gives a one-cycle completion pulse with an error code. When the base-update flag is set and the operation ends cleanly, it also gives the updated base address.

A profile input selects a stricter rule set. This profile allows only two of the four addressing modes and forbids certain register combinations. Any request that breaks a rule ends with an error and makes no memory access.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset `req_ready` is 1, `mem_valid` and `done` are 0, and every register-file entry reads 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the completion pulse has ended.
- R2: A legal request makes exactly one access for each set mask bit. The accesses go in rising register index, whatever the mode. Each access after the first uses the previous address plus 4.
- R3: With N set mask bits and base B, the first access address depends on `req_mode`. Mode 0 (increment-after) uses B. Mode 1 (increment-before) uses B+4. Mode 2 (decrement-after) uses B-4N+4. Mode 3 (decrement-before) uses B-4N.
- R4: `mem_write` is 0 for a load (`req_load`=1) and 1 for a store. On a store, `mem_wdata` equals the register-file entry for `mem_idx`. On a load, the register at `mem_idx` takes `mem_rdata` at the handshake edge. No other register changes.
- R5: `done` is high for exactly one cycle. For a legal request it is the cycle after the last handshake. For a rejected request it is the cycle after acceptance. `xfer_err` is valid while `done` is high, and 0 means success.
- R6: `wb_valid` is 1 together with `done` only when `req_wb` was set and `xfer_err` is 0. `wb_base` is then B+4N for modes 0 and 1, or B-4N for modes 2 and 3. Without `req_wb`, `wb_valid` stays 0.
- R7: In either profile, an all-zero mask gives error 1. A request with `req_wb` set and `mask[req_base_idx]` set gives error 2. A rejected request makes no memory access and changes no register.
- R8: With `req_restricted`=1, mode 1 or 2 gives error 3. Mask bit 13 set gives error 4. A load with mask bits 14 and 15 both set gives error 5. No access is made in these cases. With `req_restricted`=0 none of these combinations is an error. When several rules apply, the smallest code is reported.
- R9: When a load returns a word with bit 0 clear for register 15, register 15 keeps its old value. The remaining accesses still complete, and `xfer_err` is 6 at `done` unless an earlier rule applied.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr` and `mem_idx` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mask | input | 16 | Register selection, bit i selects register i |
| req_base | input | 32 | Base address |
| req_base_idx | input | 4 | Register index holding the base |
| req_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| req_load | input | 1 | 1 load, 0 store |
| req_wb | input | 1 | Produce updated base |
| req_restricted | input | 1 | Apply restricted rule set |
| mem_valid | output | 1 | Access presented |
| mem_ready | input | 1 | Memory accepts access |
| mem_write | output | 1 | Access is a store |
| mem_addr | output | 32 | Word address of access |
| mem_idx | output | 4 | Register index of access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid in the handshake cycle |
| rf_wr_en | input | 1 | Side write to register file |
| rf_wr_idx | input | 4 | Side write index |
| rf_wr_data | input | 32 | Side write data |
| rf_rd_idx | input | 4 | Side read index |
| rf_rd_data | output | 32 | Side read data (combinational) |
| done | output | 1 | Completion pulse |
| xfer_err | output | 3 | Error code, valid with done |
| wb_valid | output | 1 | Updated base valid |
| wb_base | output | 32 | Updated base address |

## Verification
The bench builds the block with its default parameters: sixteen 32-bit registers and a four-byte word step. With these values, registers 13, 14 and 15 exist, so every restricted-profile rule and the fault on bit 0 of register 15 can be reached. A full mask gives the longest run of sixteen accesses. Random stalls on `mem_ready` test the hold behaviour at every position in the run. Modes, masks, profiles and load data are drawn at random, and directed cases cover each error code and its priority.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } addr_mode_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_EMPTY    = 3'd1,
    ERR_WB_BASE  = 3'd2,
    ERR_MODE     = 3'd3,
    ERR_SP_LIST  = 3'd4,
    ERR_LR_PC    = 3'd5,
    ERR_PC_ALIGN = 3'd6
  } xfer_err_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/blkxfer_rules.sv
module blkxfer_rules
  import blkxfer_pkg::*;
#(
  parameter int NREGS = 16
) (
  input  logic [NREGS-1:0]         mask,
  input  logic [$clog2(NREGS)-1:0] base_idx,
  input  addr_mode_e               mode,
  input  logic                     is_load,
  input  logic                     wb,
  input  logic                     restricted,
  output xfer_err_e                err
);
  localparam int SP_IDX = NREGS - 3;
  localparam int LR_IDX = NREGS - 2;
  localparam int PC_IDX = NREGS - 1;

  logic mode_banned;
  assign mode_banned = (mode == AM_INC_BEFORE) || (mode == AM_DEC_AFTER);

  // lowest code wins
  always_comb begin
    err = ERR_NONE;
    if (mask == '0)                                          err = ERR_EMPTY;
    else if (wb && mask[base_idx])                           err = ERR_WB_BASE;
    else if (restricted && mode_banned)                      err = ERR_MODE;
    else if (restricted && mask[SP_IDX])                     err = ERR_SP_LIST;
    else if (restricted && is_load && mask[LR_IDX] && mask[PC_IDX]) err = ERR_LR_PC;
  end
endmodule

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
  parameter int NREGS = 16
) (
  input  logic [NREGS-1:0]         vec,
  output logic [$clog2(NREGS)-1:0] idx,
  output logic                     any,
  output logic                     last
);
  localparam int IDXW = $clog2(NREGS);

  logic [NREGS:0]   seen;
  logic [NREGS-1:0] first_oh;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NREGS; g++) begin : g_scan
    assign first_oh[g] = vec[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | vec[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (first_oh[i]) idx = IDXW'(i);
    end
  end

  assign any  = seen[NREGS];
  assign last = any && ((vec & ~first_oh) == '0);
endmodule

// File: rtl/blkxfer_regfile.sv
module blkxfer_regfile #(
  parameter int NREGS = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NREGS)-1:0] raddr_a,
  output logic [DW-1:0]            rdata_a,
  input  logic [$clog2(NREGS)-1:0] raddr_b,
  output logic [DW-1:0]            rdata_b
);
  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(waddr)] == $past(wdata)); // R4
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int NREGS      = 16,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [NREGS-1:0]         req_mask,
  input  logic [AW-1:0]            req_base,
  input  logic [$clog2(NREGS)-1:0] req_base_idx,
  input  logic [1:0]               req_mode,
  input  logic                     req_load,
  input  logic                     req_wb,
  input  logic                     req_restricted,
  output logic                     mem_valid,
  input  logic                     mem_ready,
  output logic                     mem_write,
  output logic [AW-1:0]            mem_addr,
  output logic [$clog2(NREGS)-1:0] mem_idx,
  output logic [DW-1:0]            mem_wdata,
  input  logic [DW-1:0]            mem_rdata,
  input  logic                     rf_wr_en,
  input  logic [$clog2(NREGS)-1:0] rf_wr_idx,
  input  logic [DW-1:0]            rf_wr_data,
  input  logic [$clog2(NREGS)-1:0] rf_rd_idx,
  output logic [DW-1:0]            rf_rd_data,
  output logic                     done,
  output logic [2:0]               xfer_err,
  output logic                     wb_valid,
  output logic [AW-1:0]            wb_base
);
  localparam int            IDXW   = $clog2(NREGS);
  localparam int            PC_IDX = NREGS - 1;
  localparam logic [AW-1:0] STEP_V = AW'(WORD_BYTES);

  // ---- address arithmetic ----
  function automatic logic [AW-1:0] span_of(input logic [NREGS-1:0] m);
    logic [AW-1:0] n;
    n = '0;
    for (int i = 0; i < NREGS; i++) if (m[i]) n = n + AW'(1);
    return n * STEP_V;
  endfunction

  function automatic logic [AW-1:0] first_addr(input logic [AW-1:0] b,
                                               input addr_mode_e md,
                                               input logic [NREGS-1:0] m);
    logic [AW-1:0] span;
    span = span_of(m);
    case (md)
      AM_INC_AFTER:  return b;
      AM_INC_BEFORE: return b + STEP_V;
      AM_DEC_AFTER:  return b - span + STEP_V;
      default:       return b - span;
    endcase
  endfunction

  function automatic logic [AW-1:0] final_base(input logic [AW-1:0] b,
                                               input addr_mode_e md,
                                               input logic [NREGS-1:0] m);
    if (md == AM_DEC_AFTER || md == AM_DEC_BEFORE) return b - span_of(m);
    return b + span_of(m);
  endfunction

  // ---- state ----
  seq_state_e       state;
  logic [NREGS-1:0] rem_mask;
  logic [AW-1:0]    cur_addr;
  logic             load_q, wb_q, pc_fault;
  xfer_err_e        err_q, rule_err, err_now;
  logic [AW-1:0]    wb_value;

  // ---- named events ----
  logic             accept, fire, pick_any, pick_last, pc_odd_bad, seq_wr;
  logic [IDXW-1:0]  pick_idx;
  addr_mode_e       mode_in;

  assign mode_in    = addr_mode_e'(req_mode);
  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign mem_valid  = (state == ST_XFER);
  assign fire       = mem_valid && mem_ready;
  assign pc_odd_bad = load_q && (pick_idx == IDXW'(PC_IDX)) && !mem_rdata[0];
  assign seq_wr     = fire && load_q && !pc_odd_bad;

  blkxfer_rules #(.NREGS(NREGS)) u_rules (
    .mask(req_mask), .base_idx(req_base_idx), .mode(mode_in),
    .is_load(req_load), .wb(req_wb), .restricted(req_restricted), .err(rule_err)
  );

  blkxfer_pick #(.NREGS(NREGS)) u_pick (
    .vec(rem_mask), .idx(pick_idx), .any(pick_any), .last(pick_last)
  );

  logic            rf_we;
  logic [IDXW-1:0] rf_waddr;
  logic [DW-1:0]   rf_wdata;

  assign rf_we    = seq_wr | rf_wr_en;
  assign rf_waddr = seq_wr ? pick_idx  : rf_wr_idx;
  assign rf_wdata = seq_wr ? mem_rdata : rf_wr_data;

  blkxfer_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(pick_idx), .rdata_a(mem_wdata), .raddr_b(rf_rd_idx), .rdata_b(rf_rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rem_mask <= '0;
      cur_addr <= '0;
      load_q   <= 1'b0;
      wb_q     <= 1'b0;
      pc_fault <= 1'b0;
      err_q    <= ERR_NONE;
      wb_value <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          err_q    <= rule_err;
          load_q   <= req_load;
          wb_q     <= req_wb;
          pc_fault <= 1'b0;
          wb_value <= final_base(req_base, mode_in, req_mask);
          if (rule_err != ERR_NONE) begin
            state    <= ST_DONE;
            rem_mask <= '0;
          end else begin
            state    <= ST_XFER;
            rem_mask <= req_mask;
            cur_addr <= first_addr(req_base, mode_in, req_mask);
          end
        end
        ST_XFER: if (fire) begin
          cur_addr           <= cur_addr + STEP_V;
          rem_mask[pick_idx] <= 1'b0;
          if (pc_odd_bad) pc_fault <= 1'b1;
          if (pick_last)  state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign err_now   = (err_q == ERR_NONE && pc_fault) ? ERR_PC_ALIGN : err_q;
  assign done      = (state == ST_DONE);
  assign xfer_err  = done ? 3'(err_now) : 3'd0;
  assign wb_valid  = done && wb_q && (err_now == ERR_NONE);
  assign wb_base   = wb_value;
  assign mem_write = !load_q;
  assign mem_addr  = cur_addr;
  assign mem_idx   = pick_idx;

  // ---- assertions ----
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pick_last) |=> mem_valid && (mem_addr == $past(mem_addr) + STEP_V)); // R2

  AST_IDX_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pick_last) |=> (mem_idx > $past(mem_idx))); // R2

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_idx)); // R10

  AST_ILLEGAL_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rule_err != ERR_NONE) |=> done && !mem_valid); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R5

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready); // R1

  AST_XFER_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> pick_any); // R2
endmodule

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [15:0] req_mask = 0;
  logic [31:0] req_base = 0;
  logic [3:0]  req_base_idx = 0;
  logic [1:0]  req_mode = 0;
  logic        req_load = 0, req_wb = 0, req_restricted = 0;
  logic        mem_valid, mem_ready = 0, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_idx;
  logic        rf_wr_en = 0;
  logic [3:0]  rf_wr_idx = 0, rf_rd_idx = 0;
  logic [31:0] rf_wr_data = 0, rf_rd_data;
  logic        done, wb_valid;
  logic [2:0]  xfer_err;
  logic [31:0] wb_base;
  logic [31:0] salt = 0;

  assign mem_rdata = (mem_addr * 32'h9E3779B1) ^ salt;

  blkxfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_base(req_base), .req_base_idx(req_base_idx),
    .req_mode(req_mode), .req_load(req_load), .req_wb(req_wb),
    .req_restricted(req_restricted), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_idx(mem_idx),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_wr_en(rf_wr_en),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .done(done), .xfer_err(xfer_err),
    .wb_valid(wb_valid), .wb_base(wb_base)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] model [16];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic int low_bit(input logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return -1;
  endfunction

  // lowest touched address: below base for descending modes, one word up for 'before' ascending / 'after' descending
  function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [1:0] md, input logic [15:0] m);
    logic [31:0] lo;
    lo = md[1] ? b - 32'(4 * popc(m)) : b;
    if (md[0] != md[1]) lo = lo + 32'd4;
    return lo;
  endfunction

  function automatic int exp_err(input logic [15:0] m, input logic [3:0] bi, input logic [1:0] md,
                                 input bit ld, input bit wb, input bit rs);
    int c = 0;
    if (rs && ld && m[14] && m[15]) c = 5;
    if (rs && m[13]) c = 4;
    if (rs && (md[0] != md[1])) c = 3;
    if (wb && m[bi]) c = 2;
    if (m == 16'h0) c = 1;
    return c;
  endfunction

  task automatic write_rf(input int i, input logic [31:0] v);
    @(negedge clk);
    rf_wr_en = 1; rf_wr_idx = 4'(i); rf_wr_data = v;
    @(negedge clk);
    rf_wr_en = 0;
    model[i] = v;
  endtask

  task automatic verify_rf(input string tag);
    bit ok = 1;
    logic [31:0] a = 0, e = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rf_rd_idx = 4'(i);
      #1;
      if (rf_rd_data !== model[i] && ok) begin ok = 0; a = rf_rd_data; e = model[i]; end
    end
    check(ok, tag, a, e);
  endtask

  // salt_lsb: -1 random, else forces bit 0 of every loaded word
  task automatic run_op(input logic [15:0] m, input logic [31:0] b, input logic [3:0] bi,
                        input logic [1:0] md, input bit ld, input bit wb, input bit rs,
                        input int stall_pct, input int salt_lsb, input string tag);
    int e, cyc;
    logic [15:0] left;
    logic [31:0] addr_e, bad_a, bad_e, exp_wb;
    bit seq_ok, data_ok, pc_bad, timed_out;
    seq_ok = 1; data_ok = 1; pc_bad = 0; timed_out = 0; cyc = 0;
    bad_a = 0; bad_e = 0;
    salt = $urandom;
    if (salt_lsb >= 0) salt[0] = salt_lsb[0];
    e = exp_err(m, bi, md, ld, wb, rs);
    left = (e == 0) ? m : 16'h0;
    addr_e = exp_first(b, md, m);
    exp_wb = md[1] ? b - 32'(4 * popc(m)) : b + 32'(4 * popc(m));
    @(negedge clk);
    req_valid = 1; req_mask = m; req_base = b; req_base_idx = bi;
    req_mode = md; req_load = ld; req_wb = wb; req_restricted = rs;
    #1;
    if (!req_ready) seq_ok = 0;
    @(negedge clk);
    req_valid = 0;
    forever begin
      mem_ready = ($urandom_range(99) >= stall_pct);
      #1;
      if (done) break;
      if (mem_valid) begin
        if (req_ready) seq_ok = 0;                       // R1 busy
        if (left == 0 || int'(mem_idx) != low_bit(left) || mem_addr != addr_e || mem_write != !ld) begin
          if (seq_ok) begin bad_a = mem_addr; bad_e = addr_e; end
          seq_ok = 0;
        end else if (mem_ready) begin
          if (!ld && mem_wdata !== model[mem_idx]) data_ok = 0;   // R4 store data
          if (ld) begin
            if (mem_idx == 4'd15 && !mem_rdata[0]) pc_bad = 1;     // R9
            else model[mem_idx] = mem_rdata;
          end
          left[mem_idx] = 1'b0;
          addr_e = addr_e + 32'd4;
        end
      end
      @(negedge clk);
      cyc++;
      if (cyc > 400) begin timed_out = 1; break; end
    end
    mem_ready = 0;
    if (e == 0 && pc_bad) e = 6;
    check(seq_ok && !timed_out && left == 0, {"R2 R3 R10 R1 access order ", tag}, bad_a, bad_e);
    check(data_ok, {"R4 store data ", tag}, 32'(data_ok), 32'd1);
    check(xfer_err == 3'(e), {"R5 R7 R8 R9 error code ", tag}, 32'(xfer_err), 32'(e));
    if (wb && e == 0)
      check(wb_valid && wb_base == exp_wb, {"R6 updated base ", tag}, wb_base, exp_wb);
    else
      check(!wb_valid, {"R6 no update ", tag}, 32'(wb_valid), 32'd0);
    @(negedge clk);
    check(!done, {"R5 single-cycle done ", tag}, 32'(done), 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(req_ready && !mem_valid && !done, "R1 reset outputs",
          {29'd0, req_ready, mem_valid, done}, 32'h4);
    verify_rf("R1 reset register file");

    for (int i = 0; i < 16; i++) write_rf(i, $urandom);

    // directed
    run_op(16'h0013, 32'h0000_4000, 4'd9, 2'd0, 1, 0, 0, 0, 1, "R3 inc-after example");
    verify_rf("R4 after load");
    run_op(16'h0000, 32'h100, 4'd0, 2'd0, 1, 0, 0, 0, -1, "R7 empty mask");
    run_op(16'h0004, 32'h100, 4'd2, 2'd1, 0, 1, 0, 0, -1, "R7 base in list with update");
    run_op(16'h0000, 32'h100, 4'd0, 2'd1, 0, 1, 1, 0, -1, "R8 priority empty over mode");
    run_op(16'h0006, 32'h200, 4'd4, 2'd1, 0, 0, 1, 0, -1, "R8 restricted inc-before");
    run_op(16'h0006, 32'h200, 4'd4, 2'd2, 0, 0, 1, 0, -1, "R8 restricted dec-after");
    run_op(16'h0006, 32'h200, 4'd4, 2'd1, 0, 1, 0, 0, -1, "R8 full profile inc-before");
    run_op(16'h2001, 32'h300, 4'd4, 2'd0, 0, 0, 1, 0, -1, "R8 restricted r13");
    run_op(16'h2001, 32'h300, 4'd4, 2'd3, 0, 1, 0, 0, -1, "R8 full profile r13");
    run_op(16'hC010, 32'h400, 4'd2, 2'd0, 1, 1, 1, 0, 1, "R8 restricted load r14 r15");
    run_op(16'hC010, 32'h400, 4'd2, 2'd3, 0, 1, 1, 0, -1, "R8 restricted store r14 r15");
    verify_rf("R7 R8 rejected ops leave registers");
    run_op(16'h8003, 32'h500, 4'd4, 2'd0, 1, 1, 0, 0, 0, "R9 r15 even word");
    verify_rf("R9 r15 kept");
    run_op(16'h40F0, 32'h2000_0200, 4'd13, 2'd3, 0, 1, 0, 0, -1, "R6 dec-before push");
    run_op(16'h40F0, 32'h2000_01EC, 4'd13, 2'd0, 1, 1, 0, 0, 1, "R6 inc-after pop");
    run_op(16'hFFFF, 32'h1000, 4'd0, 2'd2, 0, 0, 0, 90, -1, "R10 full mask heavy stall");
    run_op(16'h8000, 32'h0, 4'd1, 2'd3, 1, 1, 0, 50, 1, "R3 wrap below zero");
    verify_rf("R4 after directed");

    // random
    for (int k = 0; k < 250; k++) begin
      logic [15:0] m;
      m = 16'($urandom);
      if ($urandom_range(9) == 0) m = 16'h0;
      else if ($urandom_range(3) == 0) m = m & 16'h00FF;
      run_op(m, $urandom, 4'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
             ($urandom_range(3) == 0), $urandom_range(60), -1, "random");
      if (k % 25 == 0) verify_rf("R4 R9 random register file");
      if (k % 40 == 0) write_rf($urandom_range(15), $urandom);
    end
    verify_rf("R4 final register file");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule